// File: doc/BRIEF.md
# Core Reference and Rail-Health Monitor

This block turns a 5-bit voltage-identification code into the millivolt target of a switching core supply. It then judges four digitised sense readings against windows built from their targets: the core output and three linear outputs. The sense readings arrive already quantised as 12-bit unsigned millivolt codes, together with a one-cycle valid strobe. Each strobe is one evaluation. Every flag and every piece of hysteresis history moves only on a strobe.

The code map has two segments. The lower half runs in 50 mV steps and the upper half in 100 mV steps. The all-ones code is reserved: it disables the supply instead of naming a voltage. The core output is qualified by a lower and an upper threshold, each with its own hysteresis. A separate over-voltage trip sits above the window. Each linear output has a rising release level and a lower drop level. A four-state machine combines these results into one power-good output and one disable output.

States: `MON_RESET` (no strobe seen since reset), `MON_OFF` (disable code in force), `MON_FAULT` (some rail outside its limits), `MON_GOOD` (all rails qualified). Transitions, all taken only on a strobe:
- first-strobe: `MON_RESET` to any other state.
- enter-off: any state to `MON_OFF` on the reserved code.
- qualify: to `MON_GOOD` once every rail passes.
- drop: to `MON_FAULT` when any rail fails.

With no strobe, every state holds.

Top module: `core_rail_monitor`

## Requirements
- R1: When the code's top bit is 0, the reference is 1300 + 50 × (15 − low4) mV, where low4 is the lower four bits. So code 01111 gives 1300 and code 00000 gives 2050.
- R2: When the top bit is 1 and the code is not 11111, the reference is 2100 + 100 × (14 − low4) mV. So code 11110 gives 2100 and code 10000 gives 3500. `ref_mv_o` shows the reference captured at the latest strobe.
- R3: On a strobe with code 11111, the block enters `MON_OFF`. In that state `off_o` = 1, `pg_o` = 1 (released), `core_ov_o` = 0 and `ref_mv_o` = 0, and both core threshold histories are cleared.
- R4: Core lower edge. The core becomes "above low" when sense ≥ ceil(ref × 952 / 1024). It stops being "above low" when sense < ceil(ref × 932 / 1024). Between the two levels it keeps its last state.
- R5: Core upper edge. The core becomes "too high" when sense ≥ floor(ref × 1116 / 1024). It stops being "too high" when sense < floor(ref × 1096 / 1024). Between the two levels it keeps its last state.
- R6: `core_ov_o` equals (core sense > floor(ref × 1178 / 1024)) at each strobe, with no hysteresis.
- R7: Linear targets are as follows. Lane 0 targets 1500 mV when `sel_hi_i` = 0 and 3300 mV when `sel_hi_i` = 1. Lane 1 targets 1500 mV and lane 2 targets 1800 mV. `lin_uv_o` bit 0 belongs to lane 0, bit 1 to lane 1 and bit 2 to lane 2.
- R8: A lane's under-voltage bit clears when sense ≥ ceil(target × 768 / 1024). It sets when sense < ceil(target × 696 / 1024). Between the two levels it holds.
- R9: Outside `MON_OFF`, `pg_o` = 1 exactly when the core is above low, the core is not too high, and all three `lin_uv_o` bits are 0.
- R10: All outputs and all hysteresis state change only on clock edges where `sense_valid_i` = 1. Results appear on that same edge.
- R11: Synchronous reset gives state `MON_RESET` with `pg_o` = 0, `core_ov_o` = 0, `off_o` = 0, `lin_uv_o` = 3'b111 and `ref_mv_o` = 0.
- R12: The state machine takes the first-strobe, enter-off, qualify and drop transitions as named above. `pg_o` is 1 only in `MON_GOOD` and `MON_OFF`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| vid_i | input | 5 | Voltage-identification code |
| sel_hi_i | input | 1 | Lane 0 target select (0: 1500 mV, 1: 3300 mV) |
| sense_valid_i | input | 1 | One-cycle strobe qualifying the four sense values |
| core_mv_i | input | 12 | Core output sense, millivolts |
| lin0_mv_i | input | 12 | Lane 0 linear output sense, millivolts |
| lin1_mv_i | input | 12 | Lane 1 linear output sense, millivolts |
| lin2_mv_i | input | 12 | Lane 2 linear output sense, millivolts |
| pg_o | output | 1 | Power-good (1 = released/good) |
| core_ov_o | output | 1 | Core over-voltage flag |
| lin_uv_o | output | 3 | Per-lane under-voltage flags |
| off_o | output | 1 | Disable flag from the reserved code |
| ref_mv_o | output | 12 | Decoded core reference, millivolts |

## Verification
The assertions rely on a few properties of the inputs:
- The code, select bit and sense values are meaningful only in a cycle that carries the strobe.
- Each upper-threshold set level sits above its clear level.
- The over-voltage level sits above the upper window edge, so an over-voltage reading also leaves the upper flag set in the same strobe.

The bench follows these rules. It changes inputs only half a cycle away from the sampling edge and raises the strobe for exactly one edge per evaluation. It drives every ramp step as its own strobe, so each hysteresis band is crossed one value at a time in both directions. It also holds inputs changed with the strobe low, to show that nothing moves between strobes.

// File: rtl/crm_pkg.sv
package crm_pkg;

    // Fixed-point scale used for every threshold ratio: ratio = K / 2**SCALE_SH.
    localparam int SCALE_SH   = 10;
    localparam int SCALE_KW   = 11;

    // Core window ratios.
    localparam int K_LO_SET   = 952;
    localparam int K_LO_CLR   = 932;
    localparam int K_HI_SET   = 1116;
    localparam int K_HI_CLR   = 1096;
    localparam int K_OV       = 1178;

    // Linear under-voltage ratios.
    localparam int K_UV_REL   = 768;
    localparam int K_UV_DROP  = 696;

    // Linear lane targets in millivolts.
    localparam int LANES        = 3;
    localparam int LANE0_LO_MV  = 1500;
    localparam int LANE0_HI_MV  = 3300;
    localparam int LANE1_MV     = 1500;
    localparam int LANE2_MV     = 1800;

    typedef enum logic [1:0] {
        MON_RESET = 2'd0,
        MON_OFF   = 2'd1,
        MON_FAULT = 2'd2,
        MON_GOOD  = 2'd3
    } mon_state_t;

endpackage

// File: rtl/crm_vid_decode.sv
module crm_vid_decode #(
    parameter int VID_W      = 5,
    parameter int REF_W      = 12,
    parameter int LO_BASE_MV = 1300,
    parameter int LO_STEP_MV = 50,
    parameter int HI_BASE_MV = 2100,
    parameter int HI_STEP_MV = 100
) (
    input  logic [VID_W-1:0] vid_i,
    output logic [REF_W-1:0] ref_mv_o,
    output logic             dis_o
);

    localparam int                LOW_W   = VID_W - 1;
    localparam logic [LOW_W-1:0]  LOW_TOP = '1;
    localparam int                LOW_MAX = (1 << LOW_W) - 1;

    logic [LOW_W-1:0] low_bits;
    assign low_bits = vid_i[LOW_W-1:0];

    always_comb begin
        dis_o    = 1'b0;
        ref_mv_o = '0;
        if (!vid_i[VID_W-1]) begin
            ref_mv_o = REF_W'(LO_BASE_MV + LO_STEP_MV * (LOW_MAX - int'(low_bits)));
        end else if (low_bits == LOW_TOP) begin
            dis_o = 1'b1;
        end else begin
            ref_mv_o = REF_W'(HI_BASE_MV + HI_STEP_MV * (LOW_MAX - 1 - int'(low_bits)));
        end
    end

endmodule

// File: rtl/crm_scale.sv
module crm_scale #(
    parameter int REF_W    = 12,
    parameter int THR_W    = 13,
    parameter int KW       = 11,
    parameter int SH       = 10,
    parameter int K        = 1024,
    parameter bit ROUND_UP = 1'b0
) (
    input  logic [REF_W-1:0] ref_i,
    output logic [THR_W-1:0] thr_o
);

    localparam int               PROD_W = REF_W + KW + 1;
    localparam logic [KW-1:0]    KV     = KW'(K);

    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] sum;

    assign prod = PROD_W'(ref_i) * PROD_W'(KV);

    generate
        if (ROUND_UP) begin : g_ceil
            assign sum = prod + PROD_W'((1 << SH) - 1);
        end else begin : g_floor
            assign sum = prod;
        end
    endgenerate

    assign thr_o = THR_W'(sum >> SH);

endmodule

// File: rtl/crm_hyst_cmp.sv
module crm_hyst_cmp #(
    parameter int SENSE_W = 12,
    parameter int THR_W   = 13
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               upd_i,
    input  logic               clr_i,
    input  logic [SENSE_W-1:0] sense_i,
    input  logic [THR_W-1:0]   th_set_i,
    input  logic [THR_W-1:0]   th_clr_i,
    output logic               flag_nx_o,
    output logic               flag_q_o
);

    logic [THR_W-1:0] s_ext;
    assign s_ext = THR_W'(sense_i);

    always_comb begin
        flag_nx_o = flag_q_o;
        if (upd_i) begin
            if (clr_i)                   flag_nx_o = 1'b0;
            else if (s_ext >= th_set_i)  flag_nx_o = 1'b1;
            else if (s_ext <  th_clr_i)  flag_nx_o = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) flag_q_o <= 1'b0;
        else     flag_q_o <= flag_nx_o;
    end

    AST_HYST_QUIET: assert property (@(posedge clk) disable iff (rst)
        !upd_i |=> $stable(flag_q_o)); // R10
    AST_HYST_SET: assert property (@(posedge clk) disable iff (rst)
        (upd_i && !clr_i && (THR_W'(sense_i) >= th_set_i)) |=> flag_q_o); // R8
    AST_HYST_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (upd_i && clr_i) |=> !flag_q_o); // R3

endmodule

// File: rtl/core_rail_monitor.sv
module core_rail_monitor
    import crm_pkg::*;
#(
    parameter int VID_W   = 5,
    parameter int SENSE_W = 12,
    parameter int REF_W   = 12
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [VID_W-1:0]   vid_i,
    input  logic               sel_hi_i,
    input  logic               sense_valid_i,
    input  logic [SENSE_W-1:0] core_mv_i,
    input  logic [SENSE_W-1:0] lin0_mv_i,
    input  logic [SENSE_W-1:0] lin1_mv_i,
    input  logic [SENSE_W-1:0] lin2_mv_i,
    output logic               pg_o,
    output logic               core_ov_o,
    output logic [LANES-1:0]   lin_uv_o,
    output logic               off_o,
    output logic [REF_W-1:0]   ref_mv_o
);

    localparam int THR_W   = REF_W + 1;
    localparam int REF_MIN = 1300;
    localparam int REF_MAX = 3500;

    // ---------------- reference decode ----------------
    logic [REF_W-1:0] ref_mv;
    logic             dis;

    crm_vid_decode #(.VID_W(VID_W), .REF_W(REF_W)) u_dec (
        .vid_i    (vid_i),
        .ref_mv_o (ref_mv),
        .dis_o    (dis)
    );

    // ---------------- core thresholds ----------------
    logic [THR_W-1:0] th_lo_set, th_lo_clr, th_hi_set, th_hi_clr, th_ov;

    crm_scale #(.REF_W(REF_W), .THR_W(THR_W), .KW(SCALE_KW), .SH(SCALE_SH),
                .K(K_LO_SET), .ROUND_UP(1'b1)) u_lo_set (.ref_i(ref_mv), .thr_o(th_lo_set));
    crm_scale #(.REF_W(REF_W), .THR_W(THR_W), .KW(SCALE_KW), .SH(SCALE_SH),
                .K(K_LO_CLR), .ROUND_UP(1'b1)) u_lo_clr (.ref_i(ref_mv), .thr_o(th_lo_clr));
    crm_scale #(.REF_W(REF_W), .THR_W(THR_W), .KW(SCALE_KW), .SH(SCALE_SH),
                .K(K_HI_SET), .ROUND_UP(1'b0)) u_hi_set (.ref_i(ref_mv), .thr_o(th_hi_set));
    crm_scale #(.REF_W(REF_W), .THR_W(THR_W), .KW(SCALE_KW), .SH(SCALE_SH),
                .K(K_HI_CLR), .ROUND_UP(1'b0)) u_hi_clr (.ref_i(ref_mv), .thr_o(th_hi_clr));
    crm_scale #(.REF_W(REF_W), .THR_W(THR_W), .KW(SCALE_KW), .SH(SCALE_SH),
                .K(K_OV),     .ROUND_UP(1'b0)) u_ov     (.ref_i(ref_mv), .thr_o(th_ov));

    // ---------------- core comparators ----------------
    logic lo_ok_nx, lo_ok_q, hi_nx, hi_q;

    crm_hyst_cmp #(.SENSE_W(SENSE_W), .THR_W(THR_W)) u_core_lo (
        .clk(clk), .rst(rst), .upd_i(sense_valid_i), .clr_i(dis),
        .sense_i(core_mv_i), .th_set_i(th_lo_set), .th_clr_i(th_lo_clr),
        .flag_nx_o(lo_ok_nx), .flag_q_o(lo_ok_q)
    );

    crm_hyst_cmp #(.SENSE_W(SENSE_W), .THR_W(THR_W)) u_core_hi (
        .clk(clk), .rst(rst), .upd_i(sense_valid_i), .clr_i(dis),
        .sense_i(core_mv_i), .th_set_i(th_hi_set), .th_clr_i(th_hi_clr),
        .flag_nx_o(hi_nx), .flag_q_o(hi_q)
    );

    // ---------------- over-voltage and reference registers ----------------
    logic             ov_q;
    logic [REF_W-1:0] ref_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ov_q  <= 1'b0;
            ref_q <= '0;
        end else if (sense_valid_i) begin
            ov_q  <= !dis && (THR_W'(core_mv_i) > th_ov);
            ref_q <= dis ? '0 : ref_mv;
        end
    end

    assign core_ov_o = ov_q;
    assign ref_mv_o  = ref_q;

    // ---------------- linear lanes ----------------
    logic [LANES-1:0] above_nx, above_q;
    logic [SENSE_W-1:0] lane_sense [LANES];

    assign lane_sense[0] = lin0_mv_i;
    assign lane_sense[1] = lin1_mv_i;
    assign lane_sense[2] = lin2_mv_i;

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            logic [REF_W-1:0] tgt;
            logic [THR_W-1:0] th_rel, th_drop;

            if (g == 0) begin : g_sel
                assign tgt = sel_hi_i ? REF_W'(LANE0_HI_MV) : REF_W'(LANE0_LO_MV);
            end else if (g == 1) begin : g_fix1
                assign tgt = REF_W'(LANE1_MV);
            end else begin : g_fix2
                assign tgt = REF_W'(LANE2_MV);
            end

            crm_scale #(.REF_W(REF_W), .THR_W(THR_W), .KW(SCALE_KW), .SH(SCALE_SH),
                        .K(K_UV_REL), .ROUND_UP(1'b1)) u_rel (.ref_i(tgt), .thr_o(th_rel));
            crm_scale #(.REF_W(REF_W), .THR_W(THR_W), .KW(SCALE_KW), .SH(SCALE_SH),
                        .K(K_UV_DROP), .ROUND_UP(1'b1)) u_drop (.ref_i(tgt), .thr_o(th_drop));

            crm_hyst_cmp #(.SENSE_W(SENSE_W), .THR_W(THR_W)) u_cmp (
                .clk(clk), .rst(rst), .upd_i(sense_valid_i), .clr_i(1'b0),
                .sense_i(lane_sense[g]), .th_set_i(th_rel), .th_clr_i(th_drop),
                .flag_nx_o(above_nx[g]), .flag_q_o(above_q[g])
            );
        end
    endgenerate

    assign lin_uv_o = ~above_q;

    // ---------------- supervisor state machine ----------------
    mon_state_t state_q, state_nx, strobe_dest;
    logic       all_good_nx;

    assign all_good_nx = lo_ok_nx && !hi_nx && (&above_nx);

    always_comb begin
        if (dis)              strobe_dest = MON_OFF;    // enter-off
        else if (all_good_nx) strobe_dest = MON_GOOD;   // qualify
        else                  strobe_dest = MON_FAULT;  // drop
    end

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            MON_RESET: if (sense_valid_i) state_nx = strobe_dest;  // first-strobe
            MON_OFF:   if (sense_valid_i) state_nx = strobe_dest;
            MON_FAULT: if (sense_valid_i) state_nx = strobe_dest;
            MON_GOOD:  if (sense_valid_i) state_nx = strobe_dest;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= MON_RESET;
        else     state_q <= state_nx;
    end

    always_comb begin
        pg_o  = 1'b0;
        off_o = 1'b0;
        unique case (state_q)
            MON_RESET: ;
            MON_OFF:   begin pg_o = 1'b1; off_o = 1'b1; end
            MON_FAULT: ;
            MON_GOOD:  pg_o = 1'b1;
        endcase
    end

    // ---------------- assertions ----------------
    AST_OFF_RELEASES_PG: assert property (@(posedge clk) disable iff (rst)
        off_o |-> (pg_o && !core_ov_o && (ref_mv_o == '0))); // R3
    AST_PG_NEEDS_LANES: assert property (@(posedge clk) disable iff (rst)
        (pg_o && !off_o) |-> (lin_uv_o == '0)); // R9
    AST_OV_BLOCKS_PG: assert property (@(posedge clk) disable iff (rst)
        core_ov_o |-> !pg_o); // R6
    AST_OUTPUTS_QUIET: assert property (@(posedge clk) disable iff (rst)
        !sense_valid_i |=> $stable({pg_o, core_ov_o, lin_uv_o, off_o, ref_mv_o})); // R10
    AST_REF_RANGE: assert property (@(posedge clk) disable iff (rst)
        ((state_q != MON_RESET) && !off_o) |->
            ((ref_mv_o >= REF_W'(REF_MIN)) && (ref_mv_o <= REF_W'(REF_MAX)))); // R1
    AST_RESET_WAITS: assert property (@(posedge clk) disable iff (rst)
        (state_q == MON_RESET && !sense_valid_i) |=> (state_q == MON_RESET)); // R11

endmodule

// File: tb/core_rail_monitor_test.sv
module core_rail_monitor_test;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 26;

    typedef struct packed {
        logic [4:0]  vid;
        logic        sel;
        logic [11:0] core;
        logic [11:0] l0;
        logic [11:0] l1;
        logic [11:0] l2;
        logic        pg;
        logic        ov;
        logic [2:0]  uv;
        logic        off;
    } vec_t;

    // Sequential vectors at reference 2000 mV (code 00001); order matters (hysteresis).
    localparam vec_t TBL [NVEC] = '{
        '{5'b00001, 1'b0, 12'd2000, 12'd1500, 12'd1500, 12'd1800, 1'b1, 1'b0, 3'b000, 1'b0},
        '{5'b00001, 1'b0, 12'd1840, 12'd1500, 12'd1500, 12'd1800, 1'b1, 1'b0, 3'b000, 1'b0},
        '{5'b00001, 1'b0, 12'd1820, 12'd1500, 12'd1500, 12'd1800, 1'b0, 1'b0, 3'b000, 1'b0},
        '{5'b00001, 1'b0, 12'd1840, 12'd1500, 12'd1500, 12'd1800, 1'b0, 1'b0, 3'b000, 1'b0},
        '{5'b00001, 1'b0, 12'd1860, 12'd1500, 12'd1500, 12'd1800, 1'b1, 1'b0, 3'b000, 1'b0},
        '{5'b00001, 1'b0, 12'd2160, 12'd1500, 12'd1500, 12'd1800, 1'b1, 1'b0, 3'b000, 1'b0},
        '{5'b00001, 1'b0, 12'd2179, 12'd1500, 12'd1500, 12'd1800, 1'b0, 1'b0, 3'b000, 1'b0},
        '{5'b00001, 1'b0, 12'd2150, 12'd1500, 12'd1500, 12'd1800, 1'b0, 1'b0, 3'b000, 1'b0},
        '{5'b00001, 1'b0, 12'd2139, 12'd1500, 12'd1500, 12'd1800, 1'b1, 1'b0, 3'b000, 1'b0},
        '{5'b00001, 1'b0, 12'd2301, 12'd1500, 12'd1500, 12'd1800, 1'b0, 1'b1, 3'b000, 1'b0},
        '{5'b00001, 1'b0, 12'd2300, 12'd1500, 12'd1500, 12'd1800, 1'b0, 1'b0, 3'b000, 1'b0},
        '{5'b00001, 1'b0, 12'd2000, 12'd1500, 12'd1500, 12'd1800, 1'b1, 1'b0, 3'b000, 1'b0},
        '{5'b00001, 1'b0, 12'd2000, 12'd1124, 12'd1500, 12'd1800, 1'b1, 1'b0, 3'b000, 1'b0},
        '{5'b00001, 1'b0, 12'd2000, 12'd1019, 12'd1500, 12'd1800, 1'b0, 1'b0, 3'b001, 1'b0},
        '{5'b00001, 1'b0, 12'd2000, 12'd1124, 12'd1500, 12'd1800, 1'b0, 1'b0, 3'b001, 1'b0},
        '{5'b00001, 1'b0, 12'd2000, 12'd1125, 12'd1500, 12'd1800, 1'b1, 1'b0, 3'b000, 1'b0},
        '{5'b00001, 1'b0, 12'd2000, 12'd1500, 12'd1500, 12'd1223, 1'b0, 1'b0, 3'b100, 1'b0},
        '{5'b00001, 1'b0, 12'd2000, 12'd1500, 12'd1500, 12'd1350, 1'b1, 1'b0, 3'b000, 1'b0},
        '{5'b00001, 1'b0, 12'd2000, 12'd1500, 12'd1000, 12'd1800, 1'b0, 1'b0, 3'b010, 1'b0},
        '{5'b00001, 1'b0, 12'd2000, 12'd1500, 12'd1500, 12'd1800, 1'b1, 1'b0, 3'b000, 1'b0},
        '{5'b00001, 1'b1, 12'd2000, 12'd1500, 12'd1500, 12'd1800, 1'b0, 1'b0, 3'b001, 1'b0},
        '{5'b00001, 1'b1, 12'd2000, 12'd2474, 12'd1500, 12'd1800, 1'b0, 1'b0, 3'b001, 1'b0},
        '{5'b00001, 1'b1, 12'd2000, 12'd2475, 12'd1500, 12'd1800, 1'b1, 1'b0, 3'b000, 1'b0},
        '{5'b11111, 1'b1, 12'd2000, 12'd2475, 12'd1500, 12'd1800, 1'b1, 1'b0, 3'b000, 1'b1},
        '{5'b11111, 1'b1, 12'd4000, 12'd2475, 12'd1500, 12'd1800, 1'b1, 1'b0, 3'b000, 1'b1},
        '{5'b00001, 1'b1, 12'd2000, 12'd2475, 12'd1500, 12'd1800, 1'b1, 1'b0, 3'b000, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic [4:0]  vid;
    logic        sel;
    logic        valid;
    logic [11:0] core, l0, l1, l2;
    logic        pg_o, core_ov_o, off_o;
    logic [2:0]  lin_uv_o;
    logic [11:0] ref_mv_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    core_rail_monitor uut (
        .clk(clk), .rst(rst), .vid_i(vid), .sel_hi_i(sel), .sense_valid_i(valid),
        .core_mv_i(core), .lin0_mv_i(l0), .lin1_mv_i(l1), .lin2_mv_i(l2),
        .pg_o(pg_o), .core_ov_o(core_ov_o), .lin_uv_o(lin_uv_o), .off_o(off_o),
        .ref_mv_o(ref_mv_o)
    );

    // Reference from R1/R2 (0 for the reserved code, R3).
    function automatic int model_ref(input int code);
        if (code == 31)     return 0;
        else if (code < 16) return 1300 + 50 * (15 - code);
        else                return 2100 + 100 * (30 - code);
    endfunction

    function automatic int ratio(input int r, input int k, input bit up);
        return up ? (r * k + 1023) / 1024 : (r * k) / 1024;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic apply(input int code, input bit s, input int c, input int a, input int b, input int d);
        @(negedge clk);
        vid = 5'(code); sel = s; core = 12'(c); l0 = 12'(a); l1 = 12'(b); l2 = 12'(d);
        valid = 1'b1;
        @(negedge clk);
        valid = 1'b0;
    endtask

    task automatic check_reset_state(input string tag);
        check({tag, " R11 pg"},  int'(pg_o), 0);
        check({tag, " R11 ov"},  int'(core_ov_o), 0);
        check({tag, " R11 off"}, int'(off_o), 0);
        check({tag, " R11 uv"},  int'(lin_uv_o), 7);
        check({tag, " R11 ref"}, int'(ref_mv_o), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL R10 watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; valid = 1'b0; vid = '0; sel = 1'b0;
        core = '0; l0 = '0; l1 = '0; l2 = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_reset_state("post-reset");
        // R11: no strobe yet, state stays MON_RESET
        repeat (3) @(negedge clk);
        check("R11 idle pg", int'(pg_o), 0);

        // Vector table (R4 R5 R6 R7 R8 R9 R3 R12)
        for (int i = 0; i < NVEC; i++) begin
            apply(int'(TBL[i].vid), TBL[i].sel, int'(TBL[i].core), int'(TBL[i].l0),
                  int'(TBL[i].l1), int'(TBL[i].l2));
            check($sformatf("R9 vec%0d pg", i),  int'(pg_o), int'(TBL[i].pg));
            check($sformatf("R6 vec%0d ov", i),  int'(core_ov_o), int'(TBL[i].ov));
            check($sformatf("R8 vec%0d uv", i),  int'(lin_uv_o), int'(TBL[i].uv));
            check($sformatf("R3 vec%0d off", i), int'(off_o), int'(TBL[i].off));
        end

        // Sweep of every code (R1 R2 R3 R12)
        for (int code = 0; code < 32; code++) begin
            int r;
            r = model_ref(code);
            apply(code, 1'b0, (code == 31) ? 2000 : r, 1500, 1500, 1800);
            check($sformatf("%s code%0d ref", (code < 16) ? "R1" : "R2", code), int'(ref_mv_o), r);
            check($sformatf("R3 code%0d off", code), int'(off_o), (code == 31) ? 1 : 0);
            check($sformatf("R12 code%0d pg", code), int'(pg_o), 1);
        end

        // Threshold ramps in both directions at three references (R4 R5 R6)
        foreach (TBL[0].vid[k]) begin end
        for (int j = 0; j < 3; j++) begin
            int code, r, los, loc, his, hic, ovt;
            code = (j == 0) ? 15 : ((j == 1) ? 16 : 30);
            r   = model_ref(code);
            los = ratio(r, 952, 1'b1);
            loc = ratio(r, 932, 1'b1);
            his = ratio(r, 1116, 1'b0);
            hic = ratio(r, 1096, 1'b0);
            ovt = ratio(r, 1178, 1'b0);
            apply(code, 1'b0, 0, 1500, 1500, 1800);
            check("R4 floor drop", int'(pg_o), 0);
            apply(code, 1'b0, los - 1, 1500, 1500, 1800);
            check("R4 below set", int'(pg_o), 0);
            apply(code, 1'b0, los, 1500, 1500, 1800);
            check("R4 at set", int'(pg_o), 1);
            apply(code, 1'b0, his - 1, 1500, 1500, 1800);
            check("R5 below set", int'(pg_o), 1);
            apply(code, 1'b0, his, 1500, 1500, 1800);
            check("R5 at set", int'(pg_o), 0);
            apply(code, 1'b0, hic, 1500, 1500, 1800);
            check("R5 at clear holds", int'(pg_o), 0);
            apply(code, 1'b0, hic - 1, 1500, 1500, 1800);
            check("R5 below clear", int'(pg_o), 1);
            apply(code, 1'b0, loc, 1500, 1500, 1800);
            check("R4 at clear holds", int'(pg_o), 1);
            apply(code, 1'b0, loc - 1, 1500, 1500, 1800);
            check("R4 below clear", int'(pg_o), 0);
            apply(code, 1'b0, ovt + 1, 1500, 1500, 1800);
            check("R6 above trip", int'(core_ov_o), 1);
            apply(code, 1'b0, ovt, 1500, 1500, 1800);
            check("R6 at trip", int'(core_ov_o), 0);
        end

        // Strobe low: inputs change, nothing moves (R10)
        apply(1, 1'b0, 2000, 1500, 1500, 1800);
        check("R10 setup pg", int'(pg_o), 1);
        @(negedge clk);
        vid = 5'b11111; core = 12'd0; l0 = 12'd0; l1 = 12'd0; l2 = 12'd0;
        repeat (4) @(negedge clk);
        check("R10 hold pg",  int'(pg_o), 1);
        check("R10 hold uv",  int'(lin_uv_o), 0);
        check("R10 hold off", int'(off_o), 0);
        check("R10 hold ref", int'(ref_mv_o), 2000);
        apply(1, 1'b0, 0, 0, 0, 0);
        check("R10 strobe pg", int'(pg_o), 0);
        check("R10 strobe uv", int'(lin_uv_o), 7);

        // Mid-run reset from MON_OFF (R11)
        apply(31, 1'b0, 0, 1500, 1500, 1800);
        check("R12 enter-off", int'(off_o), 1);
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_reset_state("mid-reset");

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule